// File: doc/BRIEF.md
# HDLC Receive Deframer

This block turns a serial bit stream into framed payload bytes. It runs on the receive bit clock supplied by the line side and samples one bit per clock. It tracks runs of ones to classify each bit. A bit is either payload, a zero inserted by the transmitter, part of a delimiting flag (`01111110`), or part of an abort (seven or more ones). Payload bits are packed least-significant bit first into bytes. The bytes are handed to a backend on an 8-bit parallel output, together with one-cycle start, end, misalignment and abort markers.

Each candidate bit waits in a short delay line before it is packed. Flag and abort bits can therefore be withdrawn once the pattern is confirmed, and none of them reaches the output. After an abort the block reports an idle line when the ones run becomes long enough. Address filtering, frame check sequence handling, buffering and clock-domain crossing are left to the backend.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While reset is asserted and on the first sample after it, every output is 0.
- R2: A flag (a 0, six 1s, a 0) opens a frame. Consecutive flags, including two flags that share a zero, produce no output.
- R3: Inside a frame, a 0 that directly follows five consecutive 1s is removed from the payload.
- R4: Payload bits are packed least-significant bit first. `valid_o` is a one-cycle pulse that carries the byte on `data_o`. It is high in the cycle after the edge that samples the seventh line bit following the byte's last payload bit.
- R5: `sof_o` is high together with `valid_o` on the first byte of each frame only.
- R6: A closing flag after at least one payload bit gives a one-cycle `eof_o`. It is high in the cycle after the edge that samples the flag's final 0, and never together with `valid_o`.
- R7: `align_err_o` is high with `eof_o` when the payload bit count of the frame is not a multiple of eight. It is low with `eof_o` when the count is a multiple of eight.
- R8: A seventh consecutive 1 inside an open frame gives a one-cycle `abort_o`. The partial frame is dropped without `eof_o`.
- R9: After an abort, `idle_o` is high while the current run of 1s is at least IDLE_ONES long (default 15). It drops on the next 0.
- R10: `idle_o` stays low on a run of 1s of any length seen before any abort since reset.
- R11: Bits received after reset or after an abort, and before the next flag, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial line bit, one per clock |
| data_o | output | DATA_W | Assembled payload byte |
| valid_o | output | 1 | `data_o` carries a new byte this cycle |
| sof_o | output | 1 | Byte is the first of its frame |
| eof_o | output | 1 | Frame closed by a flag |
| abort_o | output | 1 | Open frame terminated by an abort |
| align_err_o | output | 1 | Closed frame length not a whole number of bytes |
| idle_o | output | 1 | Idle line seen after an abort |

## Verification
The bench targets payload bytes such as 0xFF, 0x7E and 0x1F, which force inserted zeros. A design that does not remove the zero shifts every later bit and corrupts all bytes after it. Two flags that share a zero, and flags sent back to back, check that the block does not report empty frames. A frame of two bytes plus three extra bits checks the misalignment flag. An abort that follows a stray 1 checks that no end marker leaks out. Long runs of 1s are sent both before any abort and after one, so an idle detector that is not gated on a prior abort is caught.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_ABORT = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic flag;
    logic abort;
    logic stuff;
    logic long_run;
  } line_evt_t;
endpackage

// File: rtl/hdlc_rx_bitdet.sv
module hdlc_rx_bitdet
  import hdlc_rx_pkg::*;
#(
  parameter int FLAG_ONES = 6,
  parameter int IDLE_ONES = 15
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bit_i,
  output line_evt_t evt_o
);
  localparam int CW = $clog2(IDLE_ONES + 1);
  localparam logic [CW-1:0] FLAG_RUN  = CW'(FLAG_ONES);
  localparam logic [CW-1:0] STUFF_RUN = CW'(FLAG_ONES - 1);
  localparam logic [CW-1:0] IDLE_RUN  = CW'(IDLE_ONES);

  logic [CW-1:0] ones_q, ones_d;

  always_comb begin
    if (!bit_i)                ones_d = '0;
    else if (ones_q == IDLE_RUN) ones_d = ones_q;
    else                       ones_d = ones_q + CW'(1);
    evt_o.flag     = !bit_i && (ones_q == FLAG_RUN);
    evt_o.abort    =  bit_i && (ones_q == FLAG_RUN);
    evt_o.stuff    = !bit_i && (ones_q == STUFF_RUN);
    evt_o.long_run = (ones_d == IDLE_RUN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ones_q <= '0;
    else         ones_q <= ones_d;
  end

  AST_FLAG_AFTER_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.flag |-> $past(bit_i)); // R2
endmodule

// File: rtl/hdlc_rx_delay.sv
module hdlc_rx_delay #(
  parameter int DEPTH = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic vld_i,
  input  logic clr_i,
  output logic bit_o,
  output logic vld_o
);
  logic [DEPTH-1:0] bit_q, vld_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          bit_q[0] <= 1'b0;
          vld_q[0] <= 1'b0;
        end else begin
          bit_q[0] <= bit_i;
          vld_q[0] <= vld_i;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          bit_q[g] <= 1'b0;
          vld_q[g] <= 1'b0;
        end else begin
          bit_q[g] <= bit_q[g-1];
          vld_q[g] <= vld_q[g-1] & ~clr_i;  // withdraw pattern bits
        end
      end
    end
  end

  assign bit_o = bit_q[DEPTH-1];
  assign vld_o = vld_q[DEPTH-1];

  AST_CLEAR_FLUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !vld_o); // R2
endmodule

// File: rtl/hdlc_rx_assembler.sv
module hdlc_rx_assembler
  import hdlc_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  line_evt_t         evt_i,
  input  logic              bit_i,
  input  logic              vld_i,
  output logic              open_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              abort_o,
  output logic              err_o,
  output logic              idle_o
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);

  rx_state_e         st_q, st_d;
  logic [DATA_W-1:0] sr_q, sr_next;
  logic [BW-1:0]     bcnt_q;
  logic              first_q, any_q, take, full;

  always_comb begin
    take    = (st_q == ST_OPEN) && vld_i && !evt_i.flag && !evt_i.abort;
    sr_next = {bit_i, sr_q[DATA_W-1:1]};  // LSB arrives first
    full    = take && (bcnt_q == LAST);
    st_d    = st_q;
    if (evt_i.flag)                          st_d = ST_OPEN;
    else if (evt_i.abort && st_q == ST_OPEN) st_d = ST_ABORT;
  end

  assign open_o = (st_q == ST_OPEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HUNT;
      sr_q    <= '0;
      bcnt_q  <= '0;
      first_q <= 1'b1;
      any_q   <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
      eof_o   <= 1'b0;
      abort_o <= 1'b0;
      err_o   <= 1'b0;
      idle_o  <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
      eof_o   <= 1'b0;
      abort_o <= 1'b0;
      err_o   <= 1'b0;
      idle_o  <= (st_d == ST_ABORT) && evt_i.long_run;
      if (evt_i.flag) begin
        if (st_q == ST_OPEN && any_q) begin
          eof_o <= 1'b1;
          err_o <= (bcnt_q != '0);
        end
        bcnt_q  <= '0;
        first_q <= 1'b1;
        any_q   <= 1'b0;
      end else if (evt_i.abort) begin
        if (st_q == ST_OPEN) abort_o <= 1'b1;
        bcnt_q  <= '0;
        first_q <= 1'b1;
        any_q   <= 1'b0;
      end else if (take) begin
        any_q <= 1'b1;
        sr_q  <= sr_next;
        if (full) begin
          data_o  <= sr_next;
          valid_o <= 1'b1;
          sof_o   <= first_q;
          first_q <= 1'b0;
          bcnt_q  <= '0;
        end else begin
          bcnt_q <= bcnt_q + BW'(1);
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R4
  AST_SOF_IN_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> valid_o); // R5
  AST_EOF_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> !valid_o && !abort_o); // R6
  AST_ERR_ON_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> eof_o); // R7
  AST_ABORT_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !open_o); // R8
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FLAG_ONES = 6,
  parameter int IDLE_ONES = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              abort_o,
  output logic              align_err_o,
  output logic              idle_o
);
  // A flag occupies FLAG_ONES+2 bits; all but the last wait in the line.
  localparam int DLY = FLAG_ONES + 1;

  line_evt_t evt;
  logic      open, enter_vld, dly_bit, dly_vld;

  hdlc_rx_bitdet #(
    .FLAG_ONES(FLAG_ONES),
    .IDLE_ONES(IDLE_ONES)
  ) i_bitdet (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (bit_i),
    .evt_o (evt)
  );

  assign enter_vld = open && !evt.stuff && !evt.flag && !evt.abort;

  hdlc_rx_delay #(
    .DEPTH(DLY)
  ) i_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (bit_i),
    .vld_i (enter_vld),
    .clr_i (evt.flag | evt.abort),
    .bit_o (dly_bit),
    .vld_o (dly_vld)
  );

  hdlc_rx_assembler #(
    .DATA_W(DATA_W)
  ) i_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .bit_i  (dly_bit),
    .vld_i  (dly_vld),
    .open_o (open),
    .data_o (data_o),
    .valid_o(valid_o),
    .sof_o  (sof_o),
    .eof_o  (eof_o),
    .abort_o(abort_o),
    .err_o  (align_err_o),
    .idle_o (idle_o)
  );

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> $past(bit_i)); // R9
endmodule

// File: tb/test_hdlc_rx_deframer.sv
module test_hdlc_rx_deframer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0;
  logic [7:0] data_o;
  logic       valid_o, sof_o, eof_o, abort_o, align_err_o, idle_o;

  hdlc_rx_deframer i_hdlc_rx_deframer (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .bit_i      (bit_i),
    .data_o     (data_o),
    .valid_o    (valid_o),
    .sof_o      (sof_o),
    .eof_o      (eof_o),
    .abort_o    (abort_o),
    .align_err_o(align_err_o),
    .idle_o     (idle_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // behavioural reference model
  int   m_ones, m_state, m_bcnt, m_first, m_any;
  int   pend[$];
  logic [7:0] m_sr, e_data;
  bit   e_valid, e_sof, e_eof, e_err, e_abort, e_idle;

  task automatic model_reset();
    m_ones = 0; m_state = 0; m_bcnt = 0; m_first = 1; m_any = 0;
    m_sr = 0; e_data = 0;
    pend.delete();
    for (int i = 0; i < 7; i++) pend.push_front(0);
    {e_valid, e_sof, e_eof, e_err, e_abort, e_idle} = '0;
  endtask

  task automatic model_step(input logic b);
    bit fl, ab, st;
    int ex;
    fl = (b == 0) && (m_ones == 6);
    ab = (b == 1) && (m_ones == 6);
    st = (b == 0) && (m_ones == 5);
    m_ones = b ? ((m_ones < 15) ? m_ones + 1 : 15) : 0;
    ex = pend.pop_back();
    if (fl || ab) for (int i = 0; i < pend.size(); i++) pend[i] = pend[i] & 1;
    pend.push_front(int'(b) + ((m_state == 1 && !st && !fl && !ab) ? 2 : 0));
    {e_valid, e_sof, e_eof, e_err, e_abort} = '0;
    if (fl) begin
      if (m_state == 1 && m_any != 0) begin
        e_eof = 1;
        e_err = (m_bcnt != 0);
      end
      m_state = 1; m_bcnt = 0; m_first = 1; m_any = 0;
    end else if (ab) begin
      if (m_state == 1) begin
        e_abort = 1;
        m_state = 2;
      end
      m_bcnt = 0; m_first = 1; m_any = 0;
    end else if (m_state == 1 && (ex >> 1) != 0) begin
      m_any = 1;
      m_sr = {ex[0], m_sr[7:1]};
      m_bcnt++;
      if (m_bcnt == 8) begin
        e_data = m_sr; e_valid = 1; e_sof = (m_first != 0);
        m_first = 0; m_bcnt = 0;
      end
    end
    e_idle = (m_state == 2) && (m_ones >= 15);
  endtask

  // observation
  int  rx_q[$];
  int  n_sof, n_eof, n_err, n_abort, idle_seen;

  task automatic clr_obs();
    rx_q.delete();
    n_sof = 0; n_eof = 0; n_err = 0; n_abort = 0; idle_seen = 0;
  endtask

  task automatic push_bit(input logic b);
    bit_i = b;
    model_step(b);
    @(posedge clk);
    @(negedge clk);
    chk(valid_o == e_valid, "R4 valid", valid_o, e_valid);
    chk(data_o == e_data, "R4 data", data_o, e_data);
    chk(sof_o == e_sof, "R5 sof", sof_o, e_sof);
    chk(eof_o == e_eof, "R6 eof", eof_o, e_eof);
    chk(align_err_o == e_err, "R7 align_err", align_err_o, e_err);
    chk(abort_o == e_abort, "R8 abort", abort_o, e_abort);
    chk(idle_o == e_idle, "R9 idle", idle_o, e_idle);
    if (valid_o) rx_q.push_back(int'(data_o));
    if (sof_o) n_sof++;
    if (eof_o) n_eof++;
    if (align_err_o) n_err++;
    if (abort_o) n_abort++;
    if (idle_o) idle_seen++;
  endtask

  // transmitter
  int tx_ones = 0;
  task automatic tx_flag();
    push_bit(0);
    for (int i = 0; i < 6; i++) push_bit(1);
    push_bit(0);
    tx_ones = 0;
  endtask
  task automatic tx_bit(input logic b);
    push_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin
        push_bit(0);
        tx_ones = 0;
      end
    end else tx_ones = 0;
  endtask
  task automatic tx_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) tx_bit(v[i]);
  endtask

  int exp_q[$];

  task automatic chk_bytes(input string req);
    chk(rx_q.size() == exp_q.size(), req, rx_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
      chk(rx_q[i] == exp_q[i], req, rx_q[i], exp_q[i]);
  endtask

  initial begin
    model_reset();
    clr_obs();
    repeat (3) @(negedge clk);
    chk({valid_o, sof_o, eof_o, abort_o, align_err_o, idle_o} == 6'b0, "R1 in reset",
        int'({valid_o, sof_o, eof_o, abort_o, align_err_o, idle_o}), 0);
    chk(data_o == 8'h00, "R1 data in reset", data_o, 0);
    rst_ni = 1'b1;
    // R1 / R10: long run of ones before any abort
    for (int i = 0; i < 20; i++) push_bit(1);
    chk(idle_seen == 0, "R10 idle before abort", idle_seen, 0);
    chk(n_abort == 0, "R10 no abort while hunting", n_abort, 0);
    // R11: junk without flag
    clr_obs();
    foreach (exp_q[i]) ;
    begin
      logic [10:0] junk = 11'b10110011010;
      for (int i = 0; i < 11; i++) push_bit(junk[i]);
    end
    chk(rx_q.size() + n_eof + n_sof == 0, "R11 junk ignored", rx_q.size() + n_eof, 0);
    // R2: back-to-back flags, then shared-zero flags
    clr_obs();
    tx_flag(); tx_flag(); tx_flag();
    for (int i = 0; i < 6; i++) push_bit(1);
    push_bit(0);
    for (int i = 0; i < 6; i++) push_bit(1);
    push_bit(0);
    chk(rx_q.size() + n_eof + n_abort == 0, "R2 empty flags", rx_q.size() + n_eof, 0);
    // R3 R4 R5 R6: frame with stuffing-heavy bytes
    clr_obs();
    exp_q = '{8'h3C, 8'hFF, 8'h7E, 8'h1F, 8'h00, 8'h81};
    tx_flag();
    foreach (exp_q[i]) tx_byte(exp_q[i][7:0]);
    tx_flag();
    chk_bytes("R3 destuffed bytes");
    chk(n_sof == 1, "R5 one sof", n_sof, 1);
    chk(n_eof == 1, "R6 one eof", n_eof, 1);
    chk(n_err == 0, "R7 aligned frame", n_err, 0);
    // R7: misaligned frame
    clr_obs();
    exp_q = '{8'h55, 8'h0F};
    foreach (exp_q[i]) tx_byte(exp_q[i][7:0]);
    tx_bit(1); tx_bit(0); tx_bit(1);
    tx_flag();
    chk_bytes("R7 bytes before misalign");
    chk(n_eof == 1 && n_err == 1, "R7 misaligned eof", n_err, 1);
    // R8 R9: abort then idle
    clr_obs();
    exp_q = '{8'hA5};
    tx_flag();
    tx_byte(8'hA5);
    push_bit(1); push_bit(0);
    for (int i = 0; i < 7; i++) push_bit(1);
    chk(n_abort == 1, "R8 abort pulse", n_abort, 1);
    chk(n_eof == 0, "R8 no eof on abort", n_eof, 0);
    chk_bytes("R8 bytes before abort");
    for (int i = 0; i < 12; i++) push_bit(1);
    chk(idle_o == 1'b1, "R9 idle after abort", idle_o, 1);
    push_bit(0);
    chk(idle_o == 1'b0, "R9 idle drops on zero", idle_o, 0);
    // R11: recovery after abort, junk then frame
    clr_obs();
    push_bit(1); push_bit(0); push_bit(0); push_bit(1);
    chk(rx_q.size() + n_eof == 0, "R11 ignored after abort", rx_q.size(), 0);
    exp_q = '{8'h42};
    tx_flag(); tx_byte(8'h42); tx_flag();
    chk_bytes("R11 recovered frame");
    chk(n_sof == 1 && n_eof == 1, "R5 recovered sof/eof", n_sof + n_eof, 2);
    // R4: longer frame with varied bytes
    clr_obs();
    exp_q.delete();
    for (int i = 0; i < 10; i++) exp_q.push_back((i * 53 + 29) & 255);
    foreach (exp_q[i]) tx_byte(exp_q[i][7:0]);
    tx_flag();
    chk_bytes("R4 varied bytes");
    chk(n_eof == 1 && n_err == 0, "R6 varied eof", n_eof, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule